// File: doc/BRIEF.md
# Transmit Descriptor and Status Ring Engine

This block is the transmit half of a frame DMA engine. Software fills a ring of two-word transmit descriptors in memory and grants the engine credits through a register write. For each credit the engine fetches the next descriptor over a single word-wide memory port. Word 0 of a descriptor is the buffer address. Word 1 holds the length and an abort flag. The engine passes the buffer address and length to a frame-output handshake and waits for the completion result. It then writes a one-word status record into a separate status ring. That record carries the result flags, the collision count and the ring slot the descriptor occupied.

Both rings wrap to their base addresses once the programmed byte length is used up. Each descriptor takes 8 bytes and each status record takes 4. Entries are always finished in ring order. A one-cycle transmit interrupt pulse marks every status record written. Reading the payload, sending it on the wire and inserting checksums are outside this block.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset `mem_req`, `fo_req` and `tx_irq` are low, the credit count is zero, and both ring offsets are zero.
- R2: A configuration write with `cfg_sel`=4 adds `cfg_wdata[3:0]` credits. The total credit count saturates at RING_ENTRIES (8), and any excess is discarded. Each finished entry consumes one credit, and the engine leaves idle only when at least one credit is held.
- R3: The engine starts an entry only when two conditions hold: bit 8 of the bus-master register (`cfg_sel`=5) is set, and bit 0 of the transmit control register (`cfg_sel`=6) is set. Otherwise it issues no memory request.
- R4: For each entry the engine reads word 0 at descriptor base (`cfg_sel`=0) plus the descriptor offset, then word 1 at that address plus 4. In word 1, bit 15 is the abort flag and bits 11:0 are the length. Bit 31 (end-of-frame) and bits 30:16 (buffer index) are not acted on.
- R5: For a descriptor that is not aborted, `fo_req` rises with `fo_addr` equal to word 0 and `fo_len` equal to word 1 bits 11:0. It stays high until `fo_done`.
- R6: The status record is written at status base (`cfg_sel`=2) plus the status offset. Its fields are:
  - bit 31 = 1 (processed)
  - bit 30 = `fo_ok`
  - bit 29 = aborted
  - bit 28 = `fo_lcrs`
  - bit 26 = `fo_owc`
  - bit 25 = `fo_und`
  - bit 24 = `fo_xcoll`
  - bits 20:16 = `fo_ncoll`
  - bits 14:0 = ring slot

  All other bits are 0.
- R7: A descriptor with the abort flag set produces no `fo_req`. Its status record has bit 29 set and bits 30, 28 through 24 and 20:16 clear.
- R8: After each entry the descriptor offset advances by 8 and wraps to 0 when it reaches the descriptor length (`cfg_sel`=1). The status offset advances by 4 and wraps at the status length (`cfg_sel`=3).
- R9: Entries complete in ring order. The slot echoed in a status record equals the descriptor offset divided by 8.
- R10: `tx_irq` is high for exactly one cycle, in the cycle after each status write is acknowledged.
- R11: Once `mem_req` is raised, it and `mem_addr` stay unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 desc base, 1 desc length, 2 status base, 3 status length, 4 enqueue, 5 bus-master, 6 tx control |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Status word being written |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| fo_req | output | 1 | Frame-output request |
| fo_addr | output | 32 | Buffer address of the frame |
| fo_len | output | 12 | Frame length in bytes |
| fo_done | input | 1 | Frame-output completion strobe |
| fo_ok | input | 1 | Sent without error |
| fo_lcrs | input | 1 | Carrier lost |
| fo_owc | input | 1 | Late collision |
| fo_und | input | 1 | Underrun |
| fo_xcoll | input | 1 | Excess collisions |
| fo_ncoll | input | 5 | Collision count |
| tx_irq | output | 1 | One-cycle pulse per status written |

## Verification
The memory model acknowledges a request on the falling edge after it sees it, and the engine accepts that acknowledge at the next rising edge. Each descriptor therefore costs two read round trips before the frame request and one write round trip after it. The frame model answers three falling edges after `fo_req` appears, and the status write follows one cycle after `fo_done` is taken. Descriptor, frame and status expectations are matched by event in a scoreboard rather than by absolute cycle. The interrupt is the one fixed-latency result: it is checked on exactly the falling edge following the acknowledged status write. Every other falling edge is checked for a stray pulse.

// File: rtl/txr_pkg.sv
// Shared types and field positions for the transmit ring engine.
package txr_pkg;

    // Sequencer states for one ring entry.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_FOUT,
        ST_WST
    } txr_state_e;

    // Frame-output completion result as latched by the sequencer.
    typedef struct packed {
        logic       ok;
        logic       lcrs;
        logic       owc;
        logic       und;
        logic       xcoll;
        logic [4:0] ncoll;
    } txr_result_t;

    // Descriptor word-1 fields that the engine decodes.
    localparam int DW1_ABORT_BIT = 15;
    localparam int DW1_LEN_W     = 12;

    // Register select codes.
    localparam logic [2:0] SEL_DBASE = 3'd0;
    localparam logic [2:0] SEL_DLEN  = 3'd1;
    localparam logic [2:0] SEL_SBASE = 3'd2;
    localparam logic [2:0] SEL_SLEN  = 3'd3;
    localparam logic [2:0] SEL_ENQ   = 3'd4;
    localparam logic [2:0] SEL_BM    = 3'd5;
    localparam logic [2:0] SEL_TXC   = 3'd6;

    // Build a status record from the result, the abort flag and the slot.
    function automatic logic [31:0] build_status(input txr_result_t r,
                                                 input logic aborted,
                                                 input logic [14:0] slot);
        logic [31:0] w;
        w        = '0;
        w[31]    = 1'b1;
        w[30]    = r.ok & ~aborted;
        w[29]    = aborted;
        w[28]    = r.lcrs;
        w[26]    = r.owc;
        w[25]    = r.und;
        w[24]    = r.xcoll;
        w[20:16] = r.ncoll;
        w[14:0]  = slot;
        return w;
    endfunction

endpackage

// File: rtl/txr_cfg_regs.sv
// Configuration register file for the transmit ring engine.
// Holds the ring bases and byte lengths and the two enable bits.
// Turns a write to the enqueue register into a one-cycle credit-add strobe.
// Assumes one register write per cycle at most.
module txr_cfg_regs #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int ENQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [ADDR_W-1:0] dbase,
    output logic [OFF_W-1:0]  dlen,
    output logic [ADDR_W-1:0] sbase,
    output logic [OFF_W-1:0]  slen,
    output logic              bm_en,
    output logic              tx_en,
    output logic              enq_stb,
    output logic [ENQ_W-1:0]  enq_val
);
    import txr_pkg::*;

    // Register storage, loaded on a write that selects it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbase <= '0;
            dlen  <= '0;
            sbase <= '0;
            slen  <= '0;
            bm_en <= 1'b0;
            tx_en <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_DBASE: dbase <= cfg_wdata[ADDR_W-1:0];
                SEL_DLEN:  dlen  <= cfg_wdata[OFF_W-1:0];
                SEL_SBASE: sbase <= cfg_wdata[ADDR_W-1:0];
                SEL_SLEN:  slen  <= cfg_wdata[OFF_W-1:0];
                SEL_BM:    bm_en <= cfg_wdata[8];
                SEL_TXC:   tx_en <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // Credit-add strobe decode.
    always_comb begin
        enq_stb = cfg_we && (cfg_sel == SEL_ENQ);
        enq_val = cfg_wdata[ENQ_W-1:0];
    end

endmodule

// File: rtl/txr_credit.sv
// Pending-credit counter for the transmit ring engine.
// Adds software credits and removes one per completed entry.
// Saturates at RING_ENTRIES; any excess credit is dropped.
module txr_credit #(
    parameter int RING_ENTRIES = 8,
    parameter int ENQ_W        = 4,
    localparam int CNT_W       = $clog2(RING_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_stb,
    input  logic [ENQ_W-1:0] enq_val,
    input  logic             consume,
    output logic             credit_nz
);
    localparam int SUM_W = ((CNT_W > ENQ_W) ? CNT_W : ENQ_W) + 1;
    localparam logic [SUM_W-1:0] CAP = SUM_W'(RING_ENTRIES);

    logic [CNT_W-1:0] count;
    logic [SUM_W-1:0] sum;

    // Next-count arithmetic with saturation at the ring size.
    always_comb begin
        sum = SUM_W'(count) + (enq_stb ? SUM_W'(enq_val) : '0) - (consume ? SUM_W'(1) : '0);
        if (sum > CAP) sum = CAP;
    end

    // Credit register.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= sum[CNT_W-1:0];
    end

    assign credit_nz = (count != '0);

    assert_credit_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(RING_ENTRIES));

endmodule

// File: rtl/txr_ring_ptr.sv
// Descriptor and status ring offsets for the transmit ring engine.
// Both offsets advance on each finished entry and wrap at their byte lengths.
// Assumes each length is a non-zero multiple of its entry size.
module txr_ring_ptr #(
    parameter int OFF_W   = 16,
    parameter int DESC_SZ = 8,
    parameter int STAT_SZ = 4,
    localparam int SLOT_SH = $clog2(DESC_SZ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [OFF_W-1:0] dlen,
    input  logic [OFF_W-1:0] slen,
    output logic [OFF_W-1:0] doff,
    output logic [OFF_W-1:0] soff,
    output logic [14:0]      slot
);
    logic [OFF_W:0] dnext;
    logic [OFF_W:0] snext;

    // Candidate next offsets, one bit wider so the wrap compare cannot overflow.
    always_comb begin
        dnext = {1'b0, doff} + (OFF_W+1)'(DESC_SZ);
        snext = {1'b0, soff} + (OFF_W+1)'(STAT_SZ);
    end

    // Offset registers with wrap to the ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            doff <= '0;
            soff <= '0;
        end else if (advance) begin
            doff <= (dnext >= {1'b0, dlen}) ? '0 : dnext[OFF_W-1:0];
            soff <= (snext >= {1'b0, slen}) ? '0 : snext[OFF_W-1:0];
        end
    end

    assign slot = 15'(doff >> SLOT_SH);

    assert_desc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (doff == '0) || (doff == $past(doff) + OFF_W'(DESC_SZ)));

endmodule

// File: rtl/txr_seq.sv
// Per-entry sequencer for the transmit ring engine.
// Steps: read descriptor word 0, read word 1, run the frame-output handshake
// (skipped on abort), write the status record, then pulse the interrupt.
// Assumes the memory port holds mem_ack for one cycle per accepted request.
module txr_seq #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              credit_nz,
    input  logic [ADDR_W-1:0] dbase,
    input  logic [ADDR_W-1:0] sbase,
    input  logic [OFF_W-1:0]  doff,
    input  logic [OFF_W-1:0]  soff,
    input  logic [14:0]       slot,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              fo_req,
    output logic [ADDR_W-1:0] fo_addr,
    output logic [11:0]       fo_len,
    input  logic              fo_done,
    input  txr_pkg::txr_result_t fo_res,
    output logic              done,
    output logic              tx_irq
);
    import txr_pkg::*;

    txr_state_e  state;
    logic [ADDR_W-1:0] buf_addr;
    logic [DW1_LEN_W-1:0] buf_len;
    logic        aborted;
    txr_result_t res;

    // State machine and descriptor/result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            buf_addr <= '0;
            buf_len  <= '0;
            aborted  <= 1'b0;
            res      <= '0;
            tx_irq   <= 1'b0;
        end else begin
            tx_irq <= 1'b0;
            case (state)
                ST_IDLE: if (go) state <= ST_RD0;
                ST_RD0: if (mem_ack) begin
                    buf_addr <= mem_rdata[ADDR_W-1:0];
                    state    <= ST_RD1;
                end
                ST_RD1: if (mem_ack) begin
                    buf_len <= mem_rdata[DW1_LEN_W-1:0];
                    aborted <= mem_rdata[DW1_ABORT_BIT];
                    res     <= '0;
                    state   <= mem_rdata[DW1_ABORT_BIT] ? ST_WST : ST_FOUT;
                end
                ST_FOUT: if (fo_done) begin
                    res   <= fo_res;
                    state <= ST_WST;
                end
                ST_WST: if (mem_ack) begin
                    tx_irq <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port drive for the current step.
    always_comb begin
        mem_req   = (state == ST_RD0) || (state == ST_RD1) || (state == ST_WST);
        mem_we    = (state == ST_WST);
        mem_wdata = build_status(res, aborted, slot);
        case (state)
            ST_RD0:  mem_addr = dbase + ADDR_W'(doff);
            ST_RD1:  mem_addr = dbase + ADDR_W'(doff) + ADDR_W'(4);
            ST_WST:  mem_addr = sbase + ADDR_W'(soff);
            default: mem_addr = '0;
        endcase
    end

    // Frame-output request and completion strobe.
    always_comb begin
        fo_req  = (state == ST_FOUT);
        fo_addr = buf_addr;
        fo_len  = buf_len;
        done    = (state == ST_WST) && mem_ack;
    end

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    assert_fo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fo_req && !fo_done |=> fo_req);
    assert_busy_has_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> credit_nz);
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

endmodule

// File: rtl/tx_ring_engine.sv
// Transmit descriptor and status ring engine (top).
// Wires the register file, credit counter, ring offsets and sequencer together.
// Assumes software programs bases and lengths before enabling the engine.
module tx_ring_engine #(
    parameter int RING_ENTRIES = 8,
    parameter int ADDR_W       = 32,
    parameter int OFF_W        = 16,
    localparam int ENQ_W       = $clog2(RING_ENTRIES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        fo_req,
    output logic [31:0] fo_addr,
    output logic [11:0] fo_len,
    input  logic        fo_done,
    input  logic        fo_ok,
    input  logic        fo_lcrs,
    input  logic        fo_owc,
    input  logic        fo_und,
    input  logic        fo_xcoll,
    input  logic [4:0]  fo_ncoll,
    output logic        tx_irq
);
    import txr_pkg::*;

    logic [ADDR_W-1:0] dbase, sbase;
    logic [OFF_W-1:0]  dlen, slen, doff, soff;
    logic [14:0]       slot;
    logic              bm_en, tx_en, enq_stb, credit_nz, done;
    logic [ENQ_W-1:0]  enq_val;
    txr_result_t       fo_res;

    assign fo_res = '{ok: fo_ok, lcrs: fo_lcrs, owc: fo_owc, und: fo_und,
                      xcoll: fo_xcoll, ncoll: fo_ncoll};

    txr_cfg_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENQ_W(ENQ_W)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata,
        .dbase, .dlen, .sbase, .slen, .bm_en, .tx_en, .enq_stb, .enq_val
    );

    txr_credit #(.RING_ENTRIES(RING_ENTRIES), .ENQ_W(ENQ_W)) u_credit (
        .clk, .rst_n, .enq_stb, .enq_val, .consume(done), .credit_nz
    );

    txr_ring_ptr #(.OFF_W(OFF_W)) u_ptr (
        .clk, .rst_n, .advance(done), .dlen, .slen, .doff, .soff, .slot
    );

    txr_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
        .clk, .rst_n, .go(credit_nz && bm_en && tx_en), .credit_nz,
        .dbase, .sbase, .doff, .soff, .slot,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
        .fo_req, .fo_addr, .fo_len, .fo_done, .fo_res, .done, .tx_irq
    );

    assert_idle_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req && !fo_req && !(bm_en && tx_en) |=> !mem_req);

endmodule

// File: tb/tx_ring_engine_bench.sv
module tx_ring_engine_bench;
    localparam logic [31:0] DBASE = 32'h100;
    localparam logic [31:0] SBASE = 32'h200;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
    logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 0; logic mem_ack = 0;
    logic fo_req; logic [31:0] fo_addr; logic [11:0] fo_len;
    logic fo_done = 0, fo_ok = 0, fo_lcrs = 0, fo_owc = 0, fo_und = 0, fo_xcoll = 0;
    logic [4:0] fo_ncoll = 0;
    logic tx_irq;

    int errors = 0, checks = 0;
    int rd_count = 0, st_count = 0, fo_wait = 0;
    bit irq_due = 0;
    int next_slot = 0;
    logic [31:0] mem [0:255];
    logic [31:0] q_st_addr[$], q_st_data[$], q_fo_addr[$];
    logic [11:0] q_fo_len[$];
    logic [9:0]  q_fo_resp[$];

    always #5 clk = ~clk;

    tx_ring_engine u_tx_ring_engine (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    // Driver: place a descriptor in the next slot and queue what must follow.
    task automatic post_desc(input logic [31:0] baddr, input logic [11:0] len,
                             input bit abort, input logic [9:0] resp);
        logic [31:0] st;
        int s = next_slot;
        mem[(DBASE >> 2) + s*2]     = baddr;
        mem[(DBASE >> 2) + s*2 + 1] = {1'b1, 15'(s), abort, 3'b0, len};
        st = {1'b1, resp[9] & ~abort, abort, resp[8], 1'b0, resp[7:5], 3'b0,
              resp[4:0], 1'b0, 15'(s)};
        if (abort) st = {3'b101, 29'(s)};
        if (!abort) begin
            q_fo_addr.push_back(baddr); q_fo_len.push_back(len); q_fo_resp.push_back(resp);
        end
        q_st_addr.push_back(SBASE + 32'(s*4)); q_st_data.push_back(st);
        next_slot = (next_slot + 1) % 8;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((q_st_addr.size() != 0) && n < 5000) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        check(q_st_addr.size() == 0, req, "drain timeout/queue left",
              32'(q_st_addr.size()), 0);
    endtask

    // Memory model and status-write monitor (responds on falling edges).
    always @(negedge clk) begin
        if (irq_due) check(tx_irq === 1'b1, "R10", "irq after status write", 32'(tx_irq), 1);
        else if (tx_irq) check(0, "R10", "stray irq", 1, 0);
        irq_due = 0;
        if (!rst_n) mem_ack = 0;
        else if (mem_req && !mem_ack) begin
            mem_ack = 1;
            if (mem_we) begin
                st_count++;
                irq_due = 1;
                if (q_st_addr.size() == 0) check(0, "R9", "unexpected status write", mem_addr, 0);
                else begin
                    logic [31:0] ea, ed;
                    ea = q_st_addr.pop_front(); ed = q_st_data.pop_front();
                    check(mem_addr == ea, "R8", "status address", mem_addr, ea);
                    check(mem_wdata == ed, "R6", "status word", mem_wdata, ed);
                end
                mem[mem_addr[9:2]] = mem_wdata;
            end else begin
                rd_count++;
                mem_rdata = mem[mem_addr[9:2]];
            end
        end else mem_ack = 0;
    end

    // Frame-output model and request monitor.
    always @(negedge clk) begin
        if (fo_done) fo_done = 0;
        else if (rst_n && fo_req) begin
            if (fo_wait == 2) begin
                fo_wait = 0;
                if (q_fo_addr.size() == 0) check(0, "R7", "unexpected frame request", fo_addr, 0);
                else begin
                    logic [31:0] ea; logic [11:0] el; logic [9:0] r;
                    ea = q_fo_addr.pop_front(); el = q_fo_len.pop_front(); r = q_fo_resp.pop_front();
                    check(fo_addr == ea, "R5", "frame address", fo_addr, ea);
                    check(fo_len == el, "R4", "frame length", 32'(fo_len), 32'(el));
                    {fo_ok, fo_lcrs, fo_owc, fo_und, fo_xcoll, fo_ncoll} = r;
                    fo_done = 1;
                end
            end else fo_wait++;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "ALL", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int r0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(mem_req === 0, "R1", "mem_req after reset", 32'(mem_req), 0);
        check(fo_req === 0, "R1", "fo_req after reset", 32'(fo_req), 0);
        check(tx_irq === 0, "R1", "irq after reset", 32'(tx_irq), 0);

        cfg_write(3'd0, DBASE); cfg_write(3'd1, 64);
        cfg_write(3'd2, SBASE); cfg_write(3'd3, 32);

        // R3: credit present but engine disabled, then only one enable.
        post_desc(32'h1000, 12'd60, 0, 10'b1_0000_00000);
        cfg_write(3'd4, 1);
        repeat (30) @(negedge clk);
        check(rd_count == 0, "R3", "no fetch with both enables off", 32'(rd_count), 0);
        cfg_write(3'd5, 32'h100);
        repeat (30) @(negedge clk);
        check(rd_count == 0, "R3", "no fetch with tx enable off", 32'(rd_count), 0);
        cfg_write(3'd6, 1);
        drain("R3");
        check(rd_count == 2, "R4", "two descriptor reads", 32'(rd_count), 2);

        // R6/R7: varied result flags and an abort in the middle; R2 multi-credit write.
        post_desc(32'h2000, 12'd1514, 0, 10'b0_1010_00011);
        post_desc(32'h3000, 12'd64, 1, 10'b1_0000_00000);
        post_desc(32'h4000, 12'hFFF, 0, 10'b1_0101_11111);
        cfg_write(3'd4, 3);
        drain("R7");

        // R2: saturation. Fill all 8 slots, grant 10 credits while disabled.
        cfg_write(3'd6, 0);
        for (int i = 0; i < 8; i++)
            post_desc(32'h5000 + 32'(i*16), 12'(100 + i), (i == 5), 10'(i * 37));
        cfg_write(3'd4, 5); cfg_write(3'd4, 5);
        r0 = st_count;
        cfg_write(3'd6, 1);
        drain("R8");
        check(st_count - r0 == 8, "R2", "entries after 10 credits", 32'(st_count - r0), 8);
        r0 = rd_count;
        repeat (100) @(negedge clk);
        check(rd_count == r0, "R2", "excess credits discarded", 32'(rd_count), 32'(r0));

        // R8/R9: continue past the wrap point.
        post_desc(32'h6000, 12'd1, 0, 10'b1_0000_00001);
        post_desc(32'h6100, 12'd2, 0, 10'b0_0010_00000);
        cfg_write(3'd4, 2);
        drain("R9");
        check(q_fo_addr.size() == 0, "R5", "all frames requested", 32'(q_fo_addr.size()), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule